// File: doc/BRIEF.md
# Indirect-Addressed Palette Host Port

This block is the host-side register and palette access port of a colour lookup unit. A processor reaches four targets through a single 10-bit data bus and a 2-bit select. The select picks one of four targets: an 8-bit pointer register, an 8-bit mode register, a window onto nine control registers, or a window onto a palette of 256 entries that holds 10 bits for each of the red, green and blue channels.

The control window has no address of its own. The host first writes the register index into the pointer, then reads or writes the window. The palette window transfers one colour channel per bus cycle, always in red, green, blue order, at the location held in the pointer. A hidden phase counter tracks which channel comes next. Once the blue channel has been accessed, the pointer steps to the next location, so a host can stream consecutive entries without rewriting it. Writing the pointer always restarts the sequence at red.

Top module: `pal_host_port`

## Requirements
- R1: After reset, the pointer, the mode register and every control register read as zero, the colour phase is red, and `bus_rdata` is zero.
- R2: Select 0 targets the pointer. A write loads `bus_wdata[7:0]`. A read returns the pointer in bits 7:0, with bits 9:8 reading zero.
- R3: Select 1 targets the mode register. A write stores `bus_wdata[7:0]`. A read returns it in bits 7:0, with bits 9:8 reading zero.
- R4: Select 2 targets the control register whose index is held in the pointer. Indices 0 to 8 store and return all 10 bits. Writes to indices 9 to 255 are ignored, and reads from them return zero.
- R5: Control register index 6 keeps only bits 7:0. Bits 9:8 of that register read zero whatever value was written to them.
- R6: Select 3 targets the palette entry at the pointer. Successive accesses go to the red channel, then green, then blue. Writes store all 10 bits, and reads return the channel that is due.
- R7: The pointer increments by one after a blue-channel palette access, whether that access is a read or a write. It does not change after a red or green access, after a control register access, or after a mode register access.
- R8: The pointer wraps from 8'hFF to 8'h00 when it auto-increments.
- R9: Any write to the pointer returns the colour phase to red, including a write in the middle of a triple.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. It then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus cycle strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | 0 pointer, 1 mode, 2 control window, 3 palette window |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data, one cycle after the read strobe |

## Verification
The assertions assume that `bus_sel` and `bus_we` are known whenever `bus_en` is high. They also assume that each strobe is exactly one access, so a palette access held high for several cycles counts as several channel accesses. The bench drives every input on the falling clock edge and raises `bus_en` for exactly one cycle per access. It samples `bus_rdata` at the next falling edge, which is the cycle that follows the read strobe. All 256 palette entries and all 16 low control indices are swept, and the expected values are computed arithmetically from each entry's index.

// File: rtl/pal_host_port_pkg.sv
`timescale 1ns/1ps
package pal_host_port_pkg;
  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_PAL  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  localparam int NUM_CH = 3;
endpackage

// File: rtl/pal_ptr.sv
`timescale 1ns/1ps
module pal_ptr
  import pal_host_port_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          pal_acc,
  output logic [AW-1:0] ptr_q,
  output phase_e        phase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      phase_q <= PH_RED;
    end else if (ptr_wr) begin
      ptr_q   <= ptr_wdata;
      phase_q <= PH_RED;
    end else if (pal_acc) begin
      if (phase_q == PH_BLUE) begin
        ptr_q   <= ptr_q + AW'(1);
        phase_q <= PH_RED;
      end else begin
        phase_q <= phase_e'(phase_q + 2'd1);
      end
    end
  end
endmodule

// File: rtl/pal_regs.sv
`timescale 1ns/1ps
module pal_regs #(
  parameter int DW        = 10,
  parameter int AW        = 8,
  parameter int MODE_W    = 8,
  parameter int NCTRL     = 9,
  parameter int NARROW_IX = 6,
  parameter int NARROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic              ctrl_wr,
  input  logic [AW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [DW-1:0]     ctrl_rdata
);
  localparam logic [DW-1:0] FULL_MASK   = '1;
  localparam logic [DW-1:0] NARROW_MASK = DW'((1 << NARROW_W) - 1);

  logic [DW-1:0] ctrl_q [NCTRL];

  function automatic logic [DW-1:0] keep_mask(input int i);
    return (i == NARROW_IX) ? NARROW_MASK : FULL_MASK;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (mode_wr) mode_q <= wdata[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCTRL; i++) begin
      if (rst) ctrl_q[i] <= '0;
      else if (ctrl_wr && idx == AW'(i)) ctrl_q[i] <= wdata & keep_mask(i);
    end
  end

  always_comb begin
    ctrl_rdata = '0;
    for (int i = 0; i < NCTRL; i++) begin
      if (idx == AW'(i)) ctrl_rdata = ctrl_q[i];
    end
  end
endmodule

// File: rtl/pal_ram.sv
`timescale 1ns/1ps
module pal_ram #(
  parameter int DW = 10,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/pal_host_port.sv
`timescale 1ns/1ps
module pal_host_port
  import pal_host_port_pkg::*;
#(
  parameter int DW        = 10,
  parameter int AW        = 8,
  parameter int MODE_W    = 8,
  parameter int NCTRL     = 9,
  parameter int NARROW_IX = 6,
  parameter int NARROW_W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [1:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  logic          wr_stb, rd_stb, pal_acc;
  logic [AW-1:0] addr_q;
  phase_e        phase_q;
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0] ctrl_rdata;
  logic [DW-1:0] ch_q [NUM_CH];
  logic [DW-1:0] reg_rd_q;
  logic          src_pal_q;
  logic [1:0]    rd_ch_q;
  logic [DW-1:0] reg_mux;

  assign wr_stb  = bus_en && bus_we;
  assign rd_stb  = bus_en && !bus_we;
  assign pal_acc = bus_en && (bus_sel == SEL_PAL);

  pal_ptr #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .ptr_wr    (wr_stb && bus_sel == SEL_PTR),
    .ptr_wdata (bus_wdata[AW-1:0]),
    .pal_acc   (pal_acc),
    .ptr_q     (addr_q),
    .phase_q   (phase_q)
  );

  pal_regs #(
    .DW(DW), .AW(AW), .MODE_W(MODE_W), .NCTRL(NCTRL),
    .NARROW_IX(NARROW_IX), .NARROW_W(NARROW_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (wr_stb && bus_sel == SEL_MODE),
    .ctrl_wr    (wr_stb && bus_sel == SEL_CTRL),
    .idx        (addr_q),
    .wdata      (bus_wdata),
    .mode_q     (mode_q),
    .ctrl_rdata (ctrl_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pal_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk   (clk),
      .we    (wr_stb && bus_sel == SEL_PAL && phase_q == phase_e'(c)),
      .re    (rd_stb && bus_sel == SEL_PAL && phase_q == phase_e'(c)),
      .addr  (addr_q),
      .wdata (bus_wdata),
      .q     (ch_q[c])
    );
  end

  always_comb begin
    case (bus_sel)
      SEL_PTR:  reg_mux = DW'(addr_q);
      SEL_MODE: reg_mux = DW'(mode_q);
      SEL_CTRL: reg_mux = ctrl_rdata;
      default:  reg_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q  <= '0;
      src_pal_q <= 1'b0;
      rd_ch_q   <= 2'd0;
    end else if (rd_stb) begin
      reg_rd_q  <= reg_mux;
      src_pal_q <= (bus_sel == SEL_PAL);
      rd_ch_q   <= phase_q;
    end
  end

  always_comb begin
    bus_rdata = reg_rd_q;
    if (src_pal_q) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (rd_ch_q == 2'(c)) bus_rdata = ch_q[c];
      end
    end
  end
endmodule

// File: rtl/pal_host_port_chk.sv
`timescale 1ns/1ps
module pal_host_port_chk
  import pal_host_port_pkg::*;
#(
  parameter int DW = 10,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_en,
  input logic          bus_we,
  input logic [1:0]    bus_sel,
  input logic [DW-1:0] bus_rdata,
  input logic [AW-1:0] addr_q,
  input logic [1:0]    phase_q
);
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase_q != 2'd3) else $error("phase out of range"); // R6

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_sel == SEL_PAL && phase_q == PH_BLUE)
      |=> addr_q == AW'($past(addr_q) + AW'(1))) else $error("no step"); // R7

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_sel != SEL_PTR && !(bus_sel == SEL_PAL && phase_q == PH_BLUE))
      |=> $stable(addr_q)) else $error("pointer moved"); // R7

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_we && bus_sel == SEL_PTR) |=> phase_q == PH_RED)
    else $error("phase not cleared"); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && !bus_we) |=> $stable(bus_rdata)) else $error("rdata moved"); // R10

  AST_MODE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_we && (bus_sel == SEL_MODE || bus_sel == SEL_PTR))
      |=> bus_rdata[DW-1:AW] == '0) else $error("top bits set"); // R3
endmodule

bind pal_host_port pal_host_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_sel   (bus_sel),
  .bus_rdata (bus_rdata),
  .addr_q    (addr_q),
  .phase_q   (phase_q)
);

// File: tb/pal_host_port_bench.sv
`timescale 1ns/1ps
module pal_host_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [9:0] bus_wdata = '0;
  logic [9:0] bus_rdata;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pal_host_port u_pal_host_port (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [9:0] pat(input int i, input int ch);
    return 10'((i * (37 + 2 * ch) + 5 + ch * 301) & 10'h3FF);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [9:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [9:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_sel = sel;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 rdata", bus_rdata, 10'h000);
    rd(2'd0, v); chk("R1 pointer", v, 10'h000);
    rd(2'd1, v); chk("R1 mode", v, 10'h000);
    rd(2'd2, v); chk("R1 ctrl0", v, 10'h000);
    // R6 palette write sweep starting at pointer 0
    wr(2'd0, 10'h000);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) wr(2'd3, pat(i, c));
    rd(2'd0, v); chk("R8 wrap after sweep", v, 10'h000);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        rd(2'd3, v); chk("R6 palette read", v, pat(i, c));
      end
    // R2 pointer read/write, top bits dropped
    wr(2'd0, 10'h3C7); rd(2'd0, v); chk("R2 pointer", v, 10'h0C7);
    // R3 mode
    wr(2'd1, 10'h3A5); rd(2'd1, v); chk("R3 mode", v, 10'h0A5);
    // R4 / R5 control window sweep over indices 0..15
    for (int i = 0; i < 16; i++) begin
      wr(2'd0, 10'(i)); wr(2'd2, 10'(10'h300 | (i * 11)));
      rd(2'd0, v); chk("R7 ctrl keeps pointer", v, 10'(i));
    end
    for (int i = 0; i < 16; i++) begin
      logic [9:0] e;
      e = (i >= 9) ? 10'h000 : (i == 6) ? 10'((i * 11) & 10'h0FF) : 10'(10'h300 | (i * 11));
      wr(2'd0, 10'(i)); rd(2'd2, v);
      chk(i == 6 ? "R5 narrow reg" : "R4 ctrl reg", v, e);
    end
    // R7 pointer holds after red/green reads
    wr(2'd0, 10'h040);
    rd(2'd3, v); rd(2'd3, v);
    rd(2'd0, v); chk("R7 hold after green", v, 10'h040);
    // R9 restart mid-triple
    wr(2'd0, 10'h040);
    wr(2'd3, 10'h111);
    wr(2'd0, 10'h040);
    wr(2'd3, 10'h222); wr(2'd3, 10'h333); wr(2'd3, 10'h044);
    rd(2'd0, v); chk("R7 step after blue", v, 10'h041);
    wr(2'd0, 10'h040);
    rd(2'd3, v); chk("R9 red", v, 10'h222);
    rd(2'd3, v); chk("R9 green", v, 10'h333);
    rd(2'd3, v); chk("R9 blue", v, 10'h044);
    // R8 wrap on a single triple
    wr(2'd0, 10'h0FF);
    wr(2'd3, 10'h3FF); wr(2'd3, 10'h200); wr(2'd3, 10'h001);
    rd(2'd0, v); chk("R8 wrap", v, 10'h000);
    wr(2'd0, 10'h0FF);
    rd(2'd3, v); chk("R6 full width", v, 10'h3FF);
    // R10 read data holds across a write
    wr(2'd1, 10'h055);
    chk("R10 hold", bus_rdata, 10'h3FF);
    rd(2'd1, v); chk("R10 latency", v, 10'h055);
    finish_run();
  end
endmodule